// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose I/O port of configurable width, meant for push buttons, switches and indicator lamps. A processor reaches it through a simple word-addressed register bus. It has four 32-bit registers: pin data, pin direction, interrupt enable and captured edges. The port's behaviour is fixed per instance by a parameter. It can be a pure output port, a pure input port with interrupt, or a bidirectional port where software sets the direction of each pin.

Input pins first pass through a multi-flop synchronizer. A rising edge of a synchronized pin sets that pin's capture bit, and the bit stays set until software writes to the capture register. One interrupt line is raised while any captured bit is also enabled in the interrupt enable register. A typical service routine reads the capture register to find which button fired, then writes it to clear it.

Pins are presented as separate input, output and output-enable vectors. The tristate buffer itself lives at the chip pad.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `pin_out` is 0. `pin_oe` is 0 in the input and bidirectional variants and all ones in the output-only variant.
- R2: `bus_addr` selects the register by word offset: 0 is data, 1 is direction, 2 is interrupt enable and 3 is capture. Read data bits at or above WIDTH are always zero, and `bus_rdata` follows `bus_addr` combinationally.
- R3: A rising edge on an input pin sets the matching capture bit on the third rising clock edge after the pin changes: two synchronizer stages plus the detector. A falling edge sets nothing. A set bit stays set until cleared.
- R4: Any write to offset 3 clears every capture bit at that clock edge, whatever the write data. A bit whose rising edge is detected in the same cycle stays set.
- R5: `irq` is 1 exactly when some bit is set in both the capture and the interrupt enable registers. It stays asserted until those bits are cleared or disabled.
- R6: In the input and bidirectional variants, a data read returns the synchronized pin values. A pin change shows up after two rising clock edges.
- R7: In the bidirectional variant, `pin_oe` equals the direction register, and `pin_out` equals the output latch ANDed with the direction register. A write to offset 0 loads the output latch.
- R8: In the input variant, `pin_oe` and `pin_out` stay 0 and the direction register reads zero, whatever is written to offsets 0 or 1.
- R9: In the output-only variant, a write to offset 0 loads the latch, which drives `pin_out` and is returned by data reads. Offsets 1 to 3 read zero and ignore writes, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Values driven onto the pins |
| pin_oe | output | WIDTH | Per-pin output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume that `bus_wr`, `bus_addr` and `bus_wdata` are synchronous to `clk` and stable around each edge, and that the inputs carry no unknowns after reset. The pins are taken as truly asynchronous only at the synchronizer input.

The stimulus drives every bus signal and every pin change on the falling clock edge. Random pin changes are held for at least four cycles, so the bench's model of when each edge is captured stays exact. One directed case deliberately lines up a clearing write with a freshly detected edge to check the R4 precedence.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int unsigned BUS_DW = 32;
   localparam int unsigned BUS_AW = 2;

   typedef enum logic [1:0] {
      GPIO_OUT_ONLY = 2'd0,
      GPIO_IN_IRQ   = 2'd1,
      GPIO_BIDIR    = 2'd2
   } gpio_mode_e;

   typedef enum logic [BUS_AW-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_MASK = 2'd2,
      REG_CAP  = 2'd3
   } gpio_reg_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_in,
   input  logic             clr,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] cap,
   output logic             irq
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] cap_q;
   logic [WIDTH-1:0] cap_d;

   assign rise = sync_in & ~prev_q;

   always_comb begin
      cap_d = cap_q;
      if (clr) cap_d = '0;
      cap_d = cap_d | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cap_q  <= '0;
      end else begin
         prev_q <= sync_in;
         cap_q  <= cap_d;
      end
   end

   assign cap = cap_q;
   assign irq = |(cap_q & mask);

endmodule

// File: rtl/gpio_edge_regfile.sv
module gpio_edge_regfile
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter gpio_mode_e  MODE  = GPIO_BIDIR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BUS_AW-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  sync_in,
   input  logic [WIDTH-1:0]  cap,
   output logic [BUS_DW-1:0] rdata,
   output logic [WIDTH-1:0]  lat,
   output logic [WIDTH-1:0]  dir,
   output logic [WIDTH-1:0]  mask,
   output logic              cap_clr
);

   logic wr_data, wr_dir, wr_mask, wr_cap;

   assign wr_data = wr && (addr == REG_DATA);
   assign wr_dir  = wr && (addr == REG_DIR);
   assign wr_mask = wr && (addr == REG_MASK);
   assign wr_cap  = wr && (addr == REG_CAP);

   // output latch: meaningful in output-only and bidirectional variants
   generate
      if (MODE == GPIO_IN_IRQ) begin : g_no_lat
         assign lat = '0;
      end else begin : g_lat
         logic [WIDTH-1:0] lat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lat_q <= '0;
            else if (wr_data) lat_q <= wdata;
         end
         assign lat = lat_q;
      end
   endgenerate

   // direction register only exists in the bidirectional variant
   generate
      if (MODE == GPIO_BIDIR) begin : g_dir
         logic [WIDTH-1:0] dir_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dir_q <= '0;
            else if (wr_dir) dir_q <= wdata;
         end
         assign dir = dir_q;
      end else begin : g_no_dir
         assign dir = '0;
      end
   endgenerate

   // interrupt enable and capture clear exist whenever pins are inputs
   generate
      if (MODE == GPIO_OUT_ONLY) begin : g_no_mask
         assign mask    = '0;
         assign cap_clr = 1'b0;
      end else begin : g_mask
         logic [WIDTH-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mask_q <= '0;
            else if (wr_mask) mask_q <= wdata;
         end
         assign mask    = mask_q;
         assign cap_clr = wr_cap;
      end
   endgenerate

   logic [WIDTH-1:0] data_view;

   generate
      if (MODE == GPIO_OUT_ONLY) begin : g_view_lat
         assign data_view = lat;
      end else begin : g_view_pin
         assign data_view = sync_in;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_DATA: rdata[WIDTH-1:0] = data_view;
         REG_DIR:  rdata[WIDTH-1:0] = dir;
         REG_MASK: rdata[WIDTH-1:0] = mask;
         REG_CAP:  rdata[WIDTH-1:0] = cap;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter gpio_mode_e  MODE        = GPIO_BIDIR,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic              irq
);

   generate
      if (WIDTH < 1 || WIDTH > BUS_DW) begin : g_bad_width
         $error("gpio_edge_port: WIDTH must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_edge_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sync_in;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] cap_q;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] lat;
   logic [WIDTH-1:0] dir;
   logic             cap_clr;

   generate
      if (MODE == GPIO_OUT_ONLY) begin : g_out_path
         assign sync_in = '0;
         assign rise    = '0;
         assign cap_q   = '0;
         assign irq     = 1'b0;
         assign pin_oe  = '1;
         assign pin_out = lat;
      end else begin : g_in_path
         gpio_edge_sync #(
            .WIDTH  (WIDTH),
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (pin_in),
            .sync_out (sync_in)
         );

         gpio_edge_capture #(
            .WIDTH (WIDTH)
         ) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_in),
            .clr     (cap_clr),
            .mask    (mask_q),
            .rise    (rise),
            .cap     (cap_q),
            .irq     (irq)
         );

         if (MODE == GPIO_BIDIR) begin : g_bidir_drive
            assign pin_oe  = dir;
            assign pin_out = lat & dir;
         end else begin : g_in_drive
            assign pin_oe  = '0;
            assign pin_out = '0;
         end
      end
   endgenerate

   gpio_edge_regfile #(
      .WIDTH (WIDTH),
      .MODE  (MODE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata[WIDTH-1:0]),
      .sync_in (sync_in),
      .cap     (cap_q),
      .rdata   (bus_rdata),
      .lat     (lat),
      .dir     (dir),
      .mask    (mask_q),
      .cap_clr (cap_clr)
   );

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
   import gpio_edge_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter gpio_mode_e  MODE  = GPIO_BIDIR
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic             irq,
   input logic [WIDTH-1:0] cap_q,
   input logic [WIDTH-1:0] mask_q,
   input logic [WIDTH-1:0] rise
);

   generate
      if (MODE != GPIO_OUT_ONLY) begin : g_in_props
         p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_wr && bus_addr == 2'd3) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

         p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (|rise) |=> ((cap_q & $past(rise)) == $past(rise)));

         p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 2'd3 && rise == '0) |=> (cap_q == '0));

         p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq && !(bus_wr && (bus_addr == 2'd2 || bus_addr == 2'd3))) |=> irq);

         p_mask_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 2'd2 && bus_wdata[WIDTH-1:0] == '0) |=> !irq);

         p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ((cap_q & mask_q) != '0));
      end
      if (MODE == GPIO_BIDIR) begin : g_bidir_props
         p_dir_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 2'd1) |=> (pin_oe == $past(bus_wdata[WIDTH-1:0])));
      end
      if (MODE == GPIO_OUT_ONLY) begin : g_out_props
         p_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 2'd0) |=> (pin_out == $past(bus_wdata[WIDTH-1:0])));

         p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_wr && bus_addr == 2'd0) |=> $stable(pin_out));
      end
   endgenerate

endmodule

bind gpio_edge_port gpio_edge_port_chk #(
   .WIDTH (WIDTH),
   .MODE  (MODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .cap_q     (cap_q),
   .mask_q    (mask_q),
   .rise      (rise)
);

// File: tb/sim_gpio_edge_port.sv
`timescale 1ns/1ps
module sim_gpio_edge_port;
   import gpio_edge_pkg::*;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [31:0]  bus_wdata = '0;
   logic [W-1:0] pin_in = '0;

   logic [31:0]  rd0, rd1, rd2;
   logic [W-1:0] po0, po1, po2, oe0, oe1, oe2;
   logic         irq0, irq1, irq2;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench model
   logic [W-1:0] m_pin = '0, m_lat = '0, m_dir = '0, m_mask = '0, m_cap = '0;

   always #5 clk = ~clk;

   gpio_edge_port #(.WIDTH(W), .MODE(GPIO_BIDIR)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd0), .pin_in(pin_in),
      .pin_out(po0), .pin_oe(oe0), .irq(irq0));

   gpio_edge_port #(.WIDTH(W), .MODE(GPIO_IN_IRQ)) u1 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd1), .pin_in(pin_in),
      .pin_out(po1), .pin_oe(oe1), .irq(irq1));

   gpio_edge_port #(.WIDTH(W), .MODE(GPIO_OUT_ONLY)) u2 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd2), .pin_in(pin_in),
      .pin_out(po2), .pin_oe(oe2), .irq(irq2));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] ext(input logic [W-1:0] v);
      return {{(32-W){1'b0}}, v};
   endfunction

   function automatic logic exp_irq(input logic [W-1:0] c, input logic [W-1:0] m);
      return |(c & m);
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] v);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic check_all();
      for (int a = 0; a < 4; a++) begin
         bus_addr = a[1:0];
         #1;
         case (a)
            0: begin
               chk("R6 bidir data read", rd0, ext(m_pin));
               chk("R6 input data read", rd1, ext(m_pin));
               chk("R9 out data read", rd2, ext(m_lat));
            end
            1: begin
               chk("R7 dir read", rd0, ext(m_dir));
               chk("R8 input dir reads zero", rd1, 32'h0);
               chk("R9 out dir reads zero", rd2, 32'h0);
            end
            2: begin
               chk("R2 mask read bidir", rd0, ext(m_mask));
               chk("R2 mask read input", rd1, ext(m_mask));
               chk("R9 out mask reads zero", rd2, 32'h0);
            end
            default: begin
               chk("R3 cap read bidir", rd0, ext(m_cap));
               chk("R3 cap read input", rd1, ext(m_cap));
               chk("R9 out cap reads zero", rd2, 32'h0);
            end
         endcase
      end
      chk("R5 irq bidir", {31'b0, irq0}, {31'b0, exp_irq(m_cap, m_mask)});
      chk("R5 irq input", {31'b0, irq1}, {31'b0, exp_irq(m_cap, m_mask)});
      chk("R9 irq out", {31'b0, irq2}, 32'h0);
      chk("R7 oe bidir", ext(oe0), ext(m_dir));
      chk("R7 out bidir", ext(po0), ext(m_lat & m_dir));
      chk("R8 oe input", ext(oe1), 32'h0);
      chk("R8 out input", ext(po1), 32'h0);
      chk("R9 oe out", ext(oe2), ext({W{1'b1}}));
      chk("R9 pins out", ext(po2), ext(m_lat));
   endtask

   task automatic set_pins(input logic [W-1:0] v);
      m_cap  = m_cap | (v & ~m_pin);
      m_pin  = v;
      pin_in = v;
      repeat (4) tick();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all();
      chk("R1 reset irq", {31'b0, irq0 | irq1 | irq2}, 32'h0);

      // R3/R5: rising edge on bit0 with enables
      wr(2'd2, 32'h0000_000F); m_mask = 8'h0F;
      set_pins(8'h01);
      check_all();
      // R3 timing: bit1 rise is not captured before the third edge
      pin_in = 8'h03;
      tick(); tick();
      bus_addr = 2'd3; #1;
      chk("R3 no capture after two edges", rd0, 32'h1);
      tick();
      bus_addr = 2'd3; #1;
      chk("R3 capture on third edge", rd0, 32'h3);
      m_pin = 8'h03; m_cap = 8'h03;
      tick();
      check_all();

      // R3 falling edge sets nothing
      set_pins(8'h00);
      check_all();

      // R4 clear with arbitrary data
      wr(2'd3, 32'hFFFF_FFFF); m_cap = '0;
      check_all();

      // R4 precedence: clearing write coincides with detected edge
      set_pins(8'h10);              // cap bit4 set
      pin_in = 8'h14; m_pin = 8'h14;
      tick(); tick();
      wr(2'd3, 32'h0);
      m_cap = 8'h04;
      tick();
      check_all();

      // R5 disabling the captured bit drops irq
      wr(2'd2, 32'h0000_00F0); m_mask = 8'hF0;
      check_all();
      wr(2'd2, 32'h0000_0004); m_mask = 8'h04;
      check_all();

      // R2 upper bits read zero; R7 direction and latch
      wr(2'd1, 32'hABCD_125A); m_dir = 8'h5A;
      wr(2'd0, 32'h1234_56FF); m_lat = 8'hFF;
      check_all();

      // random phase
      for (int it = 0; it < 300; it++) begin
         v = $urandom;
         case ($urandom % 5)
            0: set_pins(v[W-1:0]);
            1: begin wr(2'd2, v); m_mask = v[W-1:0]; end
            2: begin wr(2'd3, v); m_cap = '0; end
            3: begin wr(2'd1, v); m_dir = v[W-1:0]; end
            default: begin wr(2'd0, v); m_lat = v[W-1:0]; end
         endcase
         check_all();
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule